// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is the configuration register file of a PC-class chipset. Software reaches it through an index/data pair of ports on a simple 8-bit I/O bus. It first writes a register number to the index port. It then writes or reads the data port to reach that register. Only a fixed window of register numbers can be written. Register 0x00 is a read-only identification byte. Every other register outside the window reads as zero.

The contents of the writable window are driven out continuously for the memory-map and shadowing decoders that sit beside this block. An accepted data write also raises a one-cycle strobe that carries the register number, so those decoders know when to recompute their state.

Two further ports act only through side effects. Reading the A20 port opens the A20 gate, and writing it closes the gate. A read of the reset port produces a single-cycle soft-reset request for the CPU reset sequencer.

Top module: `chipset_cfg_port`

## Requirements
- R1: A write to port 0xEC loads the index register. A read of port 0xEC returns the current index, and a read of port 0xED returns the register that the index selects.
- R2: A write to port 0xED with an index from 0x02 to 0x16 inclusive stores the byte in that register. Register k is driven on `cfg_window[(k-2)*8 +: 8]`, and the new value appears on the clock edge that takes the write.
- R3: A write to port 0xED with an index outside 0x02..0x16 changes no register. This covers 0x00, 0x01, 0x17 and 0xFF.
- R4: With index 0x00, a read of port 0xED returns 0xD6. With any other index outside the window, it returns 0x00.
- R5: After a synchronous active-low reset, every writable register and the index are 0x00, `a20_gate` is 0 (gate closed), no strobe or pulse is active, and configuration access is enabled.
- R6: A read of port 0xEE opens the A20 gate (`a20_gate` goes to 1 on the next edge) if the gate was closed. A read leaves an open gate open.
- R7: A write to port 0xEE closes an open A20 gate on the next edge. It leaves a closed gate closed.
- R8: The first cycle of a read strobe on port 0xEF produces exactly one cycle of `soft_reset_req`, asserted on the following edge. Holding the read strobe high does not repeat the pulse.
- R9: A read of port 0xEE or 0xEF returns 0xFF.
- R10: Every accepted data write raises `cfg_wr_stb` for one cycle after the edge that takes it, with `cfg_wr_idx` holding the register number. An ignored write raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe; one write per cycle it is high |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| cfg_window | output | 168 | Writable registers 0x02..0x16, lowest index in the low byte |
| cfg_wr_stb | output | 1 | One-cycle pulse after an accepted data write |
| cfg_wr_idx | output | 8 | Register number of the last accepted write |
| a20_gate | output | 1 | A20 gate level, 1 = open |
| soft_reset_req | output | 1 | One-cycle CPU soft-reset request |

## Verification
The hardest cases to reach are at the edges of the writable window and in the read-strobe edge detection. The bench moves the index to 0x01, 0x02, 0x16, 0x17, 0x00 and 0xFF and writes a distinct byte to each. After each write it checks both the readback and the full window output, which shows whether an out-of-window write has leaked into a neighbour. For the reset port, the read strobe is held high for several cycles and then pulsed twice in a row, so a design that fires on the level rather than on the edge gives an extra pulse. The behavioural model is compared with the outputs every clock.

// File: rtl/chipset_cfg_pkg.sv
// Shared types for the indexed configuration port.
// Assumes an 8-bit data path; the port selection is a small enum.
package chipset_cfg_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INDEX,
        SEL_DATA,
        SEL_A20,
        SEL_RESET
    } port_sel_e;

endpackage

// File: rtl/cfg_port_decode.sv
// Address decoder: maps the I/O address onto one of the four ports.
// Assumes the four port addresses are distinct.
module cfg_port_decode
    import chipset_cfg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PORT_INDEX = 'hEC,
    parameter int PORT_DATA  = 'hED,
    parameter int PORT_A20   = 'hEE,
    parameter int PORT_RESET = 'hEF
) (
    input  logic [ADDR_W-1:0] io_addr,
    output port_sel_e         sel
);

    // Pick the port that matches the address
    always_comb begin
        if (io_addr == ADDR_W'(PORT_INDEX))      sel = SEL_INDEX;
        else if (io_addr == ADDR_W'(PORT_DATA))  sel = SEL_DATA;
        else if (io_addr == ADDR_W'(PORT_A20))   sel = SEL_A20;
        else if (io_addr == ADDR_W'(PORT_RESET)) sel = SEL_RESET;
        else                                     sel = SEL_NONE;
    end

endmodule

// File: rtl/cfg_reg_file.sv
// Index register plus the writable register window.
// Only indices WIN_LO..WIN_HI hold storage. Index ID_INDEX reads ID_VALUE,
// and every other index reads zero. Assumes WIN_LO > ID_INDEX.
module cfg_reg_file #(
    parameter int          DATA_W   = 8,
    parameter int          IDX_W    = 8,
    parameter int          WIN_LO   = 2,
    parameter int          WIN_HI   = 22,
    parameter int          ID_INDEX = 0,
    parameter logic [7:0]  ID_VALUE = 8'hD6,
    localparam int         WIN_N    = WIN_HI - WIN_LO + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    idx_we,
    input  logic                    data_we,
    input  logic [DATA_W-1:0]       wdata,
    output logic [IDX_W-1:0]        index_q,
    output logic [DATA_W-1:0]       sel_value,
    output logic [WIN_N*DATA_W-1:0] window,
    output logic                    wr_stb,
    output logic [IDX_W-1:0]        wr_idx,
    output logic                    cfg_en
);

    logic [DATA_W-1:0] regs_q [WIN_N];
    logic              in_win;
    logic              accept;

    assign in_win = (index_q >= IDX_W'(WIN_LO)) && (index_q <= IDX_W'(WIN_HI));
    assign accept = data_we && cfg_en && in_win;

    // Configuration enable: set by reset, held afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_en <= 1'b1;
    end

    // Index register load
    always_ff @(posedge clk) begin
        if (!rst_n)                index_q <= '0;
        else if (idx_we && cfg_en) index_q <= IDX_W'(wdata);
    end

    // Storage and output for each writable register
    for (genvar g = 0; g < WIN_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (accept && index_q == IDX_W'(WIN_LO + g))
                regs_q[g] <= wdata;
        end
        assign window[g*DATA_W +: DATA_W] = regs_q[g];
    end

    // Write strobe and written index toward the downstream decoders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb <= 1'b0;
            wr_idx <= '0;
        end else begin
            wr_stb <= accept;
            if (accept) wr_idx <= index_q;
        end
    end

    // Read mux for the data port
    always_comb begin
        sel_value = (index_q == IDX_W'(ID_INDEX)) ? DATA_W'(ID_VALUE) : '0;
        for (int k = 0; k < WIN_N; k++) begin
            if (index_q == IDX_W'(WIN_LO + k)) sel_value = regs_q[k];
        end
    end

    // R3
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !in_win) |=> $stable(window));

    // R10
    wr_stb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_idx >= IDX_W'(WIN_LO) && wr_idx <= IDX_W'(WIN_HI)));

    // R5
    cfg_en_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en);

endmodule

// File: rtl/cfg_side_ports.sv
// Side-effect ports: A20 gate control and the soft-reset request.
// A read of the A20 port opens the gate. A write closes it while
// configuration is enabled. A new read strobe on the reset port
// gives one clock of request.
module cfg_side_ports (
    input  logic clk,
    input  logic rst_n,
    input  logic io_rd,
    input  logic io_wr,
    input  logic hit_a20,
    input  logic hit_reset,
    input  logic cfg_en,
    output logic a20_gate,
    output logic soft_reset_req
);

    logic rd_prev;

    // A20 gate: open on read when closed, close on write when open
    always_ff @(posedge clk) begin
        if (!rst_n)                                     a20_gate <= 1'b0;
        else if (io_rd && hit_a20 && !a20_gate)         a20_gate <= 1'b1;
        else if (io_wr && hit_a20 && a20_gate && cfg_en) a20_gate <= 1'b0;
    end

    // Read strobe history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= io_rd;
    end

    // Reset request pulse on the rising edge of a read of the reset port
    always_ff @(posedge clk) begin
        if (!rst_n) soft_reset_req <= 1'b0;
        else        soft_reset_req <= io_rd && !rd_prev && hit_reset;
    end

    // R8
    reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_req |=> !soft_reset_req);

    // R6
    a20_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && hit_a20) |=> a20_gate);

    // R7
    a20_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_a20 && cfg_en && !io_rd) |=> !a20_gate);

endmodule

// File: rtl/chipset_cfg_port.sv
// Top of the indexed configuration port: decoder, register file,
// side-effect ports and the read-data mux. Reads of the side ports
// and of unknown addresses return all ones.
module chipset_cfg_port
    import chipset_cfg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WIN_LO = 2,
    parameter int WIN_HI = 22,
    localparam int WIN_N = WIN_HI - WIN_LO + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [DATA_W-1:0]       io_wdata,
    output logic [DATA_W-1:0]       io_rdata,
    output logic [WIN_N*DATA_W-1:0] cfg_window,
    output logic                    cfg_wr_stb,
    output logic [7:0]              cfg_wr_idx,
    output logic                    a20_gate,
    output logic                    soft_reset_req
);

    port_sel_e         sel;
    logic [7:0]        index_q;
    logic [DATA_W-1:0] sel_value;
    logic              cfg_en;

    cfg_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .io_addr (io_addr),
        .sel     (sel)
    );

    cfg_reg_file #(
        .DATA_W (DATA_W),
        .IDX_W  (8),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (io_wr && sel == SEL_INDEX),
        .data_we   (io_wr && sel == SEL_DATA),
        .wdata     (io_wdata),
        .index_q   (index_q),
        .sel_value (sel_value),
        .window    (cfg_window),
        .wr_stb    (cfg_wr_stb),
        .wr_idx    (cfg_wr_idx),
        .cfg_en    (cfg_en)
    );

    cfg_side_ports u_side (
        .clk            (clk),
        .rst_n          (rst_n),
        .io_rd          (io_rd),
        .io_wr          (io_wr),
        .hit_a20        (sel == SEL_A20),
        .hit_reset      (sel == SEL_RESET),
        .cfg_en         (cfg_en),
        .a20_gate       (a20_gate),
        .soft_reset_req (soft_reset_req)
    );

    // Read data mux
    always_comb begin
        case (sel)
            SEL_INDEX: io_rdata = DATA_W'(index_q);
            SEL_DATA:  io_rdata = sel_value;
            default:   io_rdata = '1;
        endcase
    end

    // R9
    side_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_A20 || sel == SEL_RESET) |-> io_rdata == '1);

endmodule

// File: tb/chipset_cfg_port_test.sv
module chipset_cfg_port_test;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [15:0]  io_addr = 0;
    logic         io_wr = 0;
    logic         io_rd = 0;
    logic [7:0]   io_wdata = 0;
    logic [7:0]   io_rdata;
    logic [167:0] cfg_window;
    logic         cfg_wr_stb;
    logic [7:0]   cfg_wr_idx;
    logic         a20_gate;
    logic         soft_reset_req;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_reg [256];
    int m_idx = 0;
    int m_a20 = 0;
    int m_prev = 0;
    int m_rst = 0;
    int m_stb = 0;
    int m_widx = 0;
    int started = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    chipset_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_window(cfg_window), .cfg_wr_stb(cfg_wr_stb),
        .cfg_wr_idx(cfg_wr_idx), .a20_gate(a20_gate),
        .soft_reset_req(soft_reset_req)
    );

    // Behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_reg[i] = 0;
            m_idx = 0; m_a20 = 0; m_prev = 0; m_rst = 0; m_stb = 0; m_widx = 0;
        end else begin
            m_stb = 0;
            m_rst = (io_rd && !m_prev && io_addr == 16'hEF) ? 1 : 0;
            m_prev = io_rd ? 1 : 0;
            if (io_rd && io_addr == 16'hEE && m_a20 == 0) m_a20 = 1;
            else if (io_wr && io_addr == 16'hEE && m_a20 == 1) m_a20 = 0;
            if (io_wr && io_addr == 16'hED && m_idx >= 2 && m_idx <= 22) begin
                m_reg[m_idx] = io_wdata;
                m_stb = 1;
                m_widx = m_idx;
            end
            if (io_wr && io_addr == 16'hEC) m_idx = io_wdata;
        end
    end

    function automatic logic [167:0] exp_window();
        logic [167:0] w;
        for (int k = 0; k < 21; k++) w[k*8 +: 8] = m_reg[k+2][7:0];
        return w;
    endfunction

    // Compare registered outputs with the model on every falling edge
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (cfg_window !== exp_window()) begin
                errors++;
                $display("FAIL R2 window: got %h exp %h", cfg_window, exp_window());
            end
            checks++;
            if (a20_gate !== m_a20[0]) begin
                errors++;
                $display("FAIL R6 a20: got %b exp %0d", a20_gate, m_a20);
            end
            checks++;
            if (soft_reset_req !== m_rst[0]) begin
                errors++;
                $display("FAIL R8 reset pulse: got %b exp %0d", soft_reset_req, m_rst);
            end
            checks++;
            if (cfg_wr_stb !== m_stb[0] || (m_stb == 1 && cfg_wr_idx !== m_widx[7:0])) begin
                errors++;
                $display("FAIL R10 strobe: got %b/%h exp %0d/%h",
                         cfg_wr_stb, cfg_wr_idx, m_stb, m_widx[7:0]);
            end
            if (soft_reset_req) pulses++;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0; io_addr = 0;
    endtask

    task automatic io_read(input logic [15:0] a, input string req, input logic [7:0] exp);
        @(negedge clk);
        io_addr = a; io_rd = 1;
        #1;
        check(req, io_rdata, exp);
        @(negedge clk);
        io_rd = 0; io_addr = 0;
    endtask

    task automatic set_and_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(16'hEC, idx);
        io_write(16'hED, d);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R5 reset state
        check("R5 window", cfg_window, 0);
        check("R5 a20", a20_gate, 0);
        io_read(16'hEC, "R5 index", 8'h00);
        // R4 id register
        io_read(16'hED, "R4 id", 8'hD6);
        // R1/R2 window edges
        set_and_write(8'h02, 8'h5A);
        io_read(16'hEC, "R1 index", 8'h02);
        io_read(16'hED, "R2 low edge", 8'h5A);
        set_and_write(8'h16, 8'hC3);
        io_read(16'hED, "R2 high edge", 8'hC3);
        set_and_write(8'h0E, 8'h81);
        io_read(16'hED, "R2 middle", 8'h81);
        // R3 out-of-window writes
        set_and_write(8'h01, 8'hAA);
        io_read(16'hED, "R3 idx01", 8'h00);
        set_and_write(8'h17, 8'hBB);
        io_read(16'hED, "R3 idx17", 8'h00);
        set_and_write(8'hFF, 8'hCC);
        io_read(16'hED, "R3 idxFF", 8'h00);
        set_and_write(8'h00, 8'h11);
        io_read(16'hED, "R3 id kept", 8'hD6);
        check("R3 window", cfg_window, exp_window());
        // R7 write closed gate stays closed, R6 open
        io_write(16'hEE, 8'h00);
        check("R7 stays closed", a20_gate, 0);
        io_read(16'hEE, "R9 a20 port", 8'hFF);
        check("R6 opened", a20_gate, 1);
        io_read(16'hEE, "R9 a20 port again", 8'hFF);
        check("R6 stays open", a20_gate, 1);
        io_write(16'hEE, 8'h00);
        check("R7 closed", a20_gate, 0);
        // R8 held read gives one pulse
        pulses = 0;
        @(negedge clk); io_addr = 16'hEF; io_rd = 1;
        #1 check("R9 reset port", io_rdata, 8'hFF);
        repeat (4) @(negedge clk);
        io_rd = 0; io_addr = 0;
        repeat (2) @(negedge clk);
        check("R8 held read one pulse", pulses, 1);
        pulses = 0;
        io_read(16'hEF, "R9 reset port", 8'hFF);
        io_read(16'hEF, "R9 reset port", 8'hFF);
        repeat (2) @(negedge clk);
        check("R8 two reads two pulses", pulses, 2);
        // R10 strobe stays low on reads and index writes
        io_write(16'hEC, 8'h05);
        io_write(16'hED, 8'h77);
        io_read(16'hED, "R10 stored", 8'h77);
        // R5 reset again clears everything
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        check("R5 window after reset", cfg_window, 0);
        io_read(16'hEC, "R5 index after reset", 8'h00);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule